// File: doc/BRIEF.md
# Interrupt Enable Register and Periodic Timers

This block keeps the byte-wide global interrupt enable register of a small controller and turns two free-running time bases plus a restartable wake-up timer into per-source interrupt requests. A single counter, clocked by the 6 MHz time-base clock, divides down to a 128 µs tick (768 cycles). A second counter divides that tick by eight to give a 1.024 ms tick (6144 cycles), so every eighth short tick lands on the same cycle as a long tick. Each tick sets a pending flag only while its enable bit is set. The flag stays set until the interrupt controller acknowledges that source.

The wake-up timer is driven by the register write itself. A write that puts a 1 in the wake-up enable bit starts the timer from zero. A write that puts a 0 there stops it and clears its count. While it runs, it fires every `WAKE_PERIOD` cycles. The timer is controlled by a three-state machine: `WK_OFF` (stopped, count held at zero), `WK_RUN` (counting) and `WK_FIRE` (the one-cycle expiry that raises the tick). The transitions are:
- `WK_OFF`→`WK_RUN` on a start write.
- `WK_RUN`→`WK_FIRE` when the count reaches `WAKE_PERIOD-1`.
- `WK_FIRE`→`WK_RUN` on the next cycle.
- `WK_RUN`→`WK_OFF` and `WK_FIRE`→`WK_OFF` on a stop write.

The GPIO and bus-activity enable bits are only stored and passed out. The logic that detects those events lives elsewhere.

Top module: `irq_enable_timers`

## Requirements
- R1: After reset the register reads 0x00, and all three requests and both pass-through enables are low.
- R2: A write with `reg_addr` = 0x20 stores bits 7 (wake-up), 6 (GPIO), 2 (1.024 ms), 1 (128 µs) and 0 (bus activity). Bits 5:3 always read 0. A write to any other address is ignored. A read of any other address returns 0x00.
- R3: While bit 1 is set, `irq_128us` is set once every 768 cycles, on the fixed phase of the free-running counter.
- R4: While bit 2 is set, `irq_1ms` is set once every 6144 cycles. It is set on the same cycle as every eighth setting of `irq_128us`.
- R5: A request stays high until its acknowledge bit is set. Acknowledge bits are: `irq_ack[0]` for 128 µs, `irq_ack[1]` for 1.024 ms, `irq_ack[2]` for wake-up. When a tick and an acknowledge meet in the same cycle, the tick wins and the request stays set.
- R6: Clearing an enable bit drops that request one cycle after the write edge and prevents it from being set again.
- R7: A write with bit 7 = 1 from the stopped state starts the wake-up timer. Its first request appears `WAKE_PERIOD`+1 cycles after the write edge. Later requests appear every `WAKE_PERIOD` cycles.
- R8: A write with bit 7 = 0 stops the wake-up timer, clears its count and drops its request. A later start again takes the full `WAKE_PERIOD`+1 cycles.
- R9: `en_gpio` follows register bit 6 and `en_bus_act` follows bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Time-base clock (6 MHz nominal) |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational on `reg_addr`) |
| irq_ack | input | 3 | Per-source acknowledge: [0] 128 µs, [1] 1.024 ms, [2] wake-up |
| irq_128us | output | 1 | 128 µs request pending |
| irq_1ms | output | 1 | 1.024 ms request pending |
| irq_wake | output | 1 | Wake-up request pending |
| en_gpio | output | 1 | GPIO interrupt enable bit |
| en_bus_act | output | 1 | Bus reset / activity interrupt enable bit |

## Verification
The assertions check on every cycle that:
- reserved bits read as zero;
- a pending 128 µs request holds until acknowledged;
- a cleared enable keeps its request low;
- every new short request follows a divider tick;
- each long tick coincides with a short tick;
- the wake-up FSM can only fire while its enable bit is set.

The exact periods (768, 6144, `WAKE_PERIOD`) can only be shown by the bench's timed scenarios. The same holds for the first-fire delay after a start write, the restart from zero after a stop, and the tick-beats-acknowledge collision.

// File: rtl/irqt_pkg.sv
package irqt_pkg;

    localparam int unsigned REG_W     = 8;
    localparam int unsigned BIT_BUS   = 0;
    localparam int unsigned BIT_T128  = 1;
    localparam int unsigned BIT_T1MS  = 2;
    localparam int unsigned BIT_GPIO  = 6;
    localparam int unsigned BIT_WAKE  = 7;
    localparam logic [REG_W-1:0] RSVD_MASK = 8'h38;

    localparam int unsigned NUM_SRC   = 3;
    localparam int unsigned SRC_T128  = 0;
    localparam int unsigned SRC_T1MS  = 1;
    localparam int unsigned SRC_WAKE  = 2;

    typedef enum logic [1:0] {
        WK_OFF  = 2'd0,
        WK_RUN  = 2'd1,
        WK_FIRE = 2'd2
    } wk_state_e;

endpackage

// File: rtl/irqt_regs.sv
module irqt_regs
    import irqt_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  en_q,
    output logic [REG_W-1:0]  rdata,
    output logic              wake_start,
    output logic              wake_stop
);

    logic hit;
    logic wr_hit;

    assign hit    = (addr == REG_ADDR);
    assign wr_hit = wr_en && hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (wr_hit) begin
            en_q <= wdata & ~RSVD_MASK;
        end
    end

    always_comb begin
        rdata      = hit ? en_q : '0;
        wake_start = wr_hit &&  wdata[BIT_WAKE];
        wake_stop  = wr_hit && !wdata[BIT_WAKE];
    end

endmodule

// File: rtl/irqt_divider.sv
module irqt_divider #(
    parameter int unsigned SUB_CYC = 768,
    parameter int unsigned RATIO   = 8
) (
    input  logic clk,
    input  logic rst,
    output logic tick_sub,
    output logic tick_main
);

    localparam int unsigned SUB_W   = $clog2(SUB_CYC);
    localparam int unsigned RATIO_W = $clog2(RATIO);
    localparam logic [SUB_W-1:0]   SUB_LAST   = SUB_W'(SUB_CYC - 1);
    localparam logic [RATIO_W-1:0] RATIO_LAST = RATIO_W'(RATIO - 1);

    logic [SUB_W-1:0]   cnt_sub;
    logic [RATIO_W-1:0] cnt_ratio;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_sub   <= '0;
            cnt_ratio <= '0;
        end else if (cnt_sub == SUB_LAST) begin
            cnt_sub   <= '0;
            cnt_ratio <= (cnt_ratio == RATIO_LAST) ? '0 : cnt_ratio + 1'b1;
        end else begin
            cnt_sub   <= cnt_sub + 1'b1;
        end
    end

    always_comb begin
        tick_sub  = (cnt_sub == SUB_LAST);
        tick_main = tick_sub && (cnt_ratio == RATIO_LAST);
    end

endmodule

// File: rtl/irqt_wake.sv
module irqt_wake
    import irqt_pkg::*;
#(
    parameter int unsigned PERIOD = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic stop,
    output logic wake_tick,
    output logic running
);

    localparam int unsigned CNT_W = $clog2(PERIOD);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PERIOD - 1);

    wk_state_e        state_q;
    wk_state_e        state_d;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WK_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WK_OFF:  if (start) state_d = WK_RUN;
            WK_RUN:  if (stop) state_d = WK_OFF;
                     else if (cnt_q == CNT_LAST) state_d = WK_FIRE;
            WK_FIRE: state_d = stop ? WK_OFF : WK_RUN;
            default: state_d = WK_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || stop) begin
            cnt_q <= '0;
        end else begin
            unique case (state_q)
                WK_OFF:  cnt_q <= '0;
                WK_RUN:  cnt_q <= (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
                WK_FIRE: cnt_q <= cnt_q + 1'b1;
                default: cnt_q <= '0;
            endcase
        end
    end

    always_comb begin
        wake_tick = (state_q == WK_FIRE);
        running   = (state_q != WK_OFF);
    end

endmodule

// File: rtl/irqt_pending.sv
module irqt_pending #(
    parameter int unsigned N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] tick,
    input  logic [N-1:0] en,
    input  logic [N-1:0] ack,
    output logic [N-1:0] pend
);

    for (genvar i = 0; i < N; i++) begin : g_src
        always_ff @(posedge clk) begin
            if (rst || !en[i]) begin
                pend[i] <= 1'b0;
            end else if (tick[i]) begin
                pend[i] <= 1'b1;
            end else if (ack[i]) begin
                pend[i] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/irq_enable_timers.sv
module irq_enable_timers
    import irqt_pkg::*;
#(
    parameter int unsigned SUB_CYC     = 768,
    parameter int unsigned RATIO       = 8,
    parameter int unsigned WAKE_PERIOD = 100
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       reg_wr,
    input  logic [7:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic [2:0] irq_ack,
    output logic       irq_128us,
    output logic       irq_1ms,
    output logic       irq_wake,
    output logic       en_gpio,
    output logic       en_bus_act
);

    logic [REG_W-1:0]   en_q;
    logic               wake_start;
    logic               wake_stop;
    logic               tick_sub;
    logic               tick_main;
    logic               wake_tick;
    logic               wake_running;
    logic [NUM_SRC-1:0] src_tick;
    logic [NUM_SRC-1:0] src_en;
    logic [NUM_SRC-1:0] src_pend;

    irqt_regs #(
        .ADDR_W   (8),
        .REG_ADDR (8'h20)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (reg_wr),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .en_q       (en_q),
        .rdata      (reg_rdata),
        .wake_start (wake_start),
        .wake_stop  (wake_stop)
    );

    irqt_divider #(
        .SUB_CYC (SUB_CYC),
        .RATIO   (RATIO)
    ) u_div (
        .clk       (clk),
        .rst       (rst),
        .tick_sub  (tick_sub),
        .tick_main (tick_main)
    );

    irqt_wake #(
        .PERIOD (WAKE_PERIOD)
    ) u_wake (
        .clk       (clk),
        .rst       (rst),
        .start     (wake_start),
        .stop      (wake_stop),
        .wake_tick (wake_tick),
        .running   (wake_running)
    );

    always_comb begin
        src_tick           = '0;
        src_en             = '0;
        src_tick[SRC_T128] = tick_sub;
        src_tick[SRC_T1MS] = tick_main;
        src_tick[SRC_WAKE] = wake_tick && wake_running;
        src_en[SRC_T128]   = en_q[BIT_T128];
        src_en[SRC_T1MS]   = en_q[BIT_T1MS];
        src_en[SRC_WAKE]   = en_q[BIT_WAKE];
    end

    irqt_pending #(
        .N (NUM_SRC)
    ) u_pend (
        .clk  (clk),
        .rst  (rst),
        .tick (src_tick),
        .en   (src_en),
        .ack  (irq_ack),
        .pend (src_pend)
    );

    always_comb begin
        irq_128us  = src_pend[SRC_T128];
        irq_1ms    = src_pend[SRC_T1MS];
        irq_wake   = src_pend[SRC_WAKE];
        en_gpio    = en_q[BIT_GPIO];
        en_bus_act = en_q[BIT_BUS];
    end

endmodule

// File: rtl/irqt_checker.sv
module irqt_checker (
    input logic       clk,
    input logic       rst,
    input logic [7:0] en_q,
    input logic [7:0] reg_rdata,
    input logic [2:0] irq_ack,
    input logic       irq_128us,
    input logic       tick_sub,
    input logic       tick_main,
    input logic       wake_tick
);

    assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[5:3] == 3'b000);

    assert_set_from_tick_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_128us) |-> $past(tick_sub));

    assert_long_on_short_R4: assert property (@(posedge clk) disable iff (rst)
        tick_main |-> tick_sub);

    assert_hold_until_ack_R5: assert property (@(posedge clk) disable iff (rst)
        (irq_128us && !irq_ack[0] && en_q[1]) |=> irq_128us);

    assert_disable_drops_R6: assert property (@(posedge clk) disable iff (rst)
        !en_q[1] |=> !irq_128us);

    assert_wake_only_enabled_R7: assert property (@(posedge clk) disable iff (rst)
        wake_tick |-> en_q[7]);

endmodule

bind irq_enable_timers irqt_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .en_q      (en_q),
    .reg_rdata (reg_rdata),
    .irq_ack   (irq_ack),
    .irq_128us (irq_128us),
    .tick_sub  (tick_sub),
    .tick_main (tick_main),
    .wake_tick (wake_tick)
);

// File: tb/irq_enable_timers_tb.sv
module irq_enable_timers_tb;

    localparam int WAKE_P = 100;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_addr = 8'h20;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic [2:0] irq_ack = 3'b000;
    logic       irq_128us, irq_1ms, irq_wake, en_gpio, en_bus_act;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_enable_timers #(.WAKE_PERIOD(WAKE_P)) u_dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_ack(irq_ack),
        .irq_128us(irq_128us), .irq_1ms(irq_1ms), .irq_wake(irq_wake),
        .en_gpio(en_gpio), .en_bus_act(en_bus_act)
    );

    // {addr, write data, expected read of 0x20 afterwards}
    localparam logic [23:0] VECS [0:5] = '{
        24'h20_FF_C7, 24'h20_38_00, 24'h21_FF_00,
        24'h20_41_41, 24'h1F_00_41, 24'h20_00_00
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 8'h20;
    endtask

    // auto-acknowledges every request seen; stops when target source is seen
    task automatic watch(input int target, input int limit,
                         output int cyc, output int n128, output int last128);
        logic [2:0] cur;
        cyc = -1; n128 = 0; last128 = -1;
        for (int c = 1; c <= limit; c++) begin
            @(negedge clk);
            cur = {irq_wake, irq_1ms, irq_128us};
            irq_ack = cur;
            if (cur[0]) begin n128++; last128 = c; end
            if (cur[target]) begin cyc = c; break; end
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        for (int i = 0; i < 150000; i++) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual 1 expected 0");
        finish_run();
    end

    initial begin
        int cyc, n128, last;
        int seen;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check("R1 rdata", reg_rdata, 0);
        check("R1 irqs", {irq_wake, irq_1ms, irq_128us}, 0);
        check("R1 enables", {en_gpio, en_bus_act}, 0);

        // R2 / R9: vector table
        for (int v = 0; v < 6; v++) begin
            wr(VECS[v][23:16], VECS[v][15:8]);
            #1;
            check("R2 readback", reg_rdata, int'(VECS[v][7:0]));
            check("R9 en_gpio", en_gpio, int'(VECS[v][6]));
            check("R9 en_bus_act", en_bus_act, int'(VECS[v][0]));
        end
        wr(8'h20, 8'h41);
        @(negedge clk); reg_addr = 8'h21; #1;
        check("R2 other address read", reg_rdata, 0);
        reg_addr = 8'h20;
        wr(8'h20, 8'h00);

        // R3: 128 us period
        wr(8'h20, 8'h02);
        watch(0, 1000, cyc, n128, last);
        watch(0, 1000, cyc, n128, last);
        check("R3 period", cyc, 768);
        watch(0, 1000, cyc, n128, last);
        check("R3 period again", cyc, 768);

        // R4: 1.024 ms period and alignment
        wr(8'h20, 8'h06);
        watch(1, 7000, cyc, n128, last);
        watch(1, 7000, cyc, n128, last);
        check("R4 period", cyc, 6144);
        check("R4 short ticks per long", n128, 8);
        check("R4 coincide", last, cyc);

        // R5: tick beats ack; hold without ack
        wr(8'h20, 8'h02);
        watch(0, 1000, cyc, n128, last);
        irq_ack = 3'b001;
        for (int k = 1; k <= 1600; k++) begin
            @(negedge clk);
            if (k == 767)  check("R5 cleared by ack", irq_128us, 0);
            if (k == 768)  check("R5 tick wins over ack", irq_128us, 1);
            if (k == 769)  check("R5 ack clears", irq_128us, 0);
            if (k == 770)  irq_ack = 3'b000;
            if (k == 1600) check("R5 held without ack", irq_128us, 1);
        end

        // R6: disable drops request
        wr(8'h20, 8'h00);
        @(negedge clk);
        check("R6 dropped", irq_128us, 0);
        seen = 0;
        for (int k = 0; k < 1000; k++) begin
            @(negedge clk);
            if (irq_128us) seen = 1;
        end
        check("R6 stays low", seen, 0);
        check("R6 readback", reg_rdata, 0);

        // R7: wake-up start and period
        wr(8'h20, 8'h80);
        watch(2, 500, cyc, n128, last);
        check("R7 first fire", cyc, WAKE_P + 1);
        watch(2, 500, cyc, n128, last);
        check("R7 period", cyc, WAKE_P);

        // R8: stop clears, restart from zero
        repeat (30) @(negedge clk);
        irq_ack = 3'b000;
        wr(8'h20, 8'h00);
        #1;
        check("R8 bit7 cleared", reg_rdata, 0);
        seen = 0;
        for (int k = 0; k < 3 * WAKE_P; k++) begin
            @(negedge clk);
            if (irq_wake) seen = 1;
        end
        check("R8 no fire while stopped", seen, 0);
        wr(8'h20, 8'h80);
        watch(2, 500, cyc, n128, last);
        check("R8 restart full period", cyc, WAKE_P + 1);
        wr(8'h20, 8'h00);
        @(negedge clk);
        check("R8 request dropped", irq_wake, 0);

        finish_run();
    end

endmodule